// File: doc/BRIEF.md
# Byte-Programmed PWM Generator

This block produces a pulse-width-modulated output whose high time and low time are each a 16-bit count of microsecond ticks. Software loads the two counts one byte at a time through a small write port. Three of the four byte writes only fill holding registers. Writing the high byte of the on-time commits the whole on/off pair at once, so the waveform never runs with a half-updated setting. A committed pair is not picked up mid-period. It is taken at the start of the next high phase.

A free-running microsecond tick paces the counters, and the counters move only in cycles where that tick is set. A mode input selects between endless repetition and a single pulse. A single pulse is one high phase, after which the output holds low until the block is re-enabled or a new commit arrives. A gate option ANDs the waveform with an external input. Dropping the enable forces the output low and clears the phase state, so the next enable starts a full high phase.

Top module: `dutyword_pwm`

## Requirements
- R1: After reset the output is low and both committed counts are zero, so enabling without programming keeps the output low.
- R2: Writes to address 0 (on-time low byte), 2 (off-time low byte) and 3 (off-time high byte) do not change the running waveform. A write to address 1 (on-time high byte) commits on = {address 1 data, address 0 byte} and off = {address 3 byte, address 2 byte}.
- R3: The high phase lasts `on` tick cycles and the low phase lasts `off` tick cycles. Counters advance only in cycles with `tick_us` = 1, and the output holds while the tick is 0.
- R4: With on = 1, off = 1 and the tick set every cycle, the output alternates high and low each cycle (50% duty).
- R5: With `one_shot` = 0, the high/low period repeats without end.
- R6: With `one_shot` = 1, the output makes one high phase and then holds low. A commit, or lowering and raising `run_en`, starts a new high phase.
- R7: With `gate_en` = 1 the output is the internal waveform ANDed with `gate_in`. With `gate_en` = 0, `gate_in` has no effect.
- R8: While `run_en` is 0 the output is low one cycle later and the phase counter is cleared. Re-enabling starts a full high phase.
- R9: A commit made mid-period first shows at the next high phase. A commit landing on the same clock edge as a high-phase start applies to that phase.
- R10: On = 0 keeps the output low. Off = 0 with a nonzero on-time keeps it high in continuous mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_us | input | 1 | One-cycle enable marking one microsecond |
| wr_en | input | 1 | Byte register write strobe |
| wr_addr | input | 2 | Byte register address (0..3) |
| wr_data | input | 8 | Byte write data |
| run_en | input | 1 | Generator enable |
| one_shot | input | 1 | 1 = single pulse, 0 = continuous |
| gate_en | input | 1 | 1 = AND output with gate_in |
| gate_in | input | 1 | External gating input |
| pwm_o | output | 1 | PWM output |

## Verification
Two functions can fall in the same cycle: a commit write to the on-time high byte, and the reload of the active counts at the start of a high phase. The bench times the commit write so that it is captured on exactly the clock edge where a low phase ends. It then checks that the new high phase already has the new length, which shows that the freshly committed pair is forwarded into the reload. A second commit, placed in the middle of a low phase, must leave the rest of that period at the old setting.

// File: rtl/dutyword_pwm_pkg.sv
package dutyword_pwm_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_HIGH = 2'd1,
      PH_LOW  = 2'd2,
      PH_DONE = 2'd3
   } phase_t;

   localparam int unsigned ADDR_W     = 2;
   localparam int unsigned REG_ON_LO  = 0;
   localparam int unsigned REG_ON_HI  = 1;
   localparam int unsigned REG_OFF_LO = 2;
   localparam int unsigned REG_OFF_HI = 3;
endpackage

// File: rtl/dutyword_shadow.sv
module dutyword_shadow
   import dutyword_pwm_pkg::*;
#(
   parameter int unsigned BYTE_W = 8,
   parameter int unsigned CNT_W  = 2 * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [BYTE_W-1:0] wr_data,
   output logic              commit,
   output logic [CNT_W-1:0]  nxt_on,
   output logic [CNT_W-1:0]  nxt_off,
   output logic [CNT_W-1:0]  act_on,
   output logic [CNT_W-1:0]  act_off
);
   logic [BYTE_W-1:0] hold_on_lo;
   logic [BYTE_W-1:0] hold_off_lo;
   logic [BYTE_W-1:0] hold_off_hi;

   assign commit  = wr_en && (wr_addr == ADDR_W'(REG_ON_HI));
   assign nxt_on  = commit ? {wr_data, hold_on_lo} : act_on;
   assign nxt_off = commit ? {hold_off_hi, hold_off_lo} : act_off;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_on_lo  <= '0;
         hold_off_lo <= '0;
         hold_off_hi <= '0;
      end else if (wr_en) begin
         if (wr_addr == ADDR_W'(REG_ON_LO))  hold_on_lo  <= wr_data;
         if (wr_addr == ADDR_W'(REG_OFF_LO)) hold_off_lo <= wr_data;
         if (wr_addr == ADDR_W'(REG_OFF_HI)) hold_off_hi <= wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_on  <= '0;
         act_off <= '0;
      end else if (commit) begin
         act_on  <= nxt_on;
         act_off <= nxt_off;
      end
   end
endmodule

// File: rtl/dutyword_phase.sv
module dutyword_phase
   import dutyword_pwm_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_us,
   input  logic             run_en,
   input  logic             one_shot,
   input  logic             commit,
   input  logic [CNT_W-1:0] nxt_on,
   input  logic [CNT_W-1:0] nxt_off,
   output logic [CNT_W-1:0] cur_on,
   output logic             raw_o
);
   phase_t           st, st_n;
   logic [CNT_W-1:0] cnt, cnt_n;
   logic [CNT_W-1:0] cur_off;
   logic             load;
   logic             high_end, low_end;

   assign high_end = (cur_on == '0)  || (cnt == cur_on - 1'b1);
   assign low_end  = (cur_off == '0) || (cnt == cur_off - 1'b1);

   always_comb begin
      st_n  = st;
      cnt_n = cnt;
      load  = 1'b0;
      if (!run_en) begin
         st_n  = PH_IDLE;
         cnt_n = '0;
      end else begin
         unique case (st)
            PH_IDLE: begin
               st_n  = PH_HIGH;
               cnt_n = '0;
               load  = 1'b1;
            end
            PH_HIGH: if (tick_us) begin
               if (high_end) begin
                  cnt_n = '0;
                  if (one_shot) begin
                     st_n = PH_DONE;
                  end else if (cur_off == '0) begin
                     st_n = PH_HIGH;
                     load = 1'b1;
                  end else begin
                     st_n = PH_LOW;
                  end
               end else begin
                  cnt_n = cnt + 1'b1;
               end
            end
            PH_LOW: if (tick_us) begin
               if (low_end) begin
                  cnt_n = '0;
                  if (one_shot) begin
                     st_n = PH_DONE;
                  end else begin
                     st_n = PH_HIGH;
                     load = 1'b1;
                  end
               end else begin
                  cnt_n = cnt + 1'b1;
               end
            end
            PH_DONE: if (commit) begin
               st_n  = PH_HIGH;
               cnt_n = '0;
               load  = 1'b1;
            end
            default: st_n = PH_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= PH_IDLE;
         cnt     <= '0;
         cur_on  <= '0;
         cur_off <= '0;
      end else begin
         st  <= st_n;
         cnt <= cnt_n;
         if (load) begin
            cur_on  <= nxt_on;
            cur_off <= nxt_off;
         end
      end
   end

   assign raw_o = (st == PH_HIGH) && (cur_on != '0);
endmodule

// File: rtl/dutyword_gate.sv
module dutyword_gate #(
   parameter bit HAS_GATE = 1'b1
) (
   input  logic raw_i,
   input  logic gate_en,
   input  logic gate_in,
   output logic out_o
);
   generate
      if (HAS_GATE) begin : g_gate
         assign out_o = raw_i & (gate_en ? gate_in : 1'b1);
      end else begin : g_nogate
         logic unused_gate;
         assign unused_gate = gate_en ^ gate_in;
         assign out_o = raw_i;
      end
   endgenerate
endmodule

// File: rtl/dutyword_pwm.sv
module dutyword_pwm
   import dutyword_pwm_pkg::*;
#(
   parameter int unsigned BYTE_W   = 8,
   parameter int unsigned CNT_W    = 16,
   parameter bit          HAS_GATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_us,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic              run_en,
   input  logic              one_shot,
   input  logic              gate_en,
   input  logic              gate_in,
   output logic              pwm_o
);
   generate
      if (CNT_W != 2 * BYTE_W) begin : g_bad_width
         $error("dutyword_pwm: CNT_W must equal two bytes");
      end
      if (BYTE_W < 2) begin : g_bad_byte
         $error("dutyword_pwm: BYTE_W too small");
      end
   endgenerate

   logic             commit;
   logic [CNT_W-1:0] nxt_on, nxt_off;
   logic [CNT_W-1:0] act_on, act_off;
   logic [CNT_W-1:0] cur_on;
   logic             raw;
   logic             unused_off;

   assign unused_off = ^act_off;

   dutyword_shadow #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_shadow (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .commit(commit), .nxt_on(nxt_on),
      .nxt_off(nxt_off), .act_on(act_on), .act_off(act_off)
   );

   dutyword_phase #(.CNT_W(CNT_W)) u_phase (
      .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .run_en(run_en),
      .one_shot(one_shot), .commit(commit), .nxt_on(nxt_on),
      .nxt_off(nxt_off), .cur_on(cur_on), .raw_o(raw)
   );

   dutyword_gate #(.HAS_GATE(HAS_GATE)) u_gate (
      .raw_i(raw), .gate_en(gate_en), .gate_in(gate_in), .out_o(pwm_o)
   );
endmodule

// File: rtl/dutyword_pwm_chk.sv
module dutyword_pwm_chk #(
   parameter int unsigned CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             run_en,
   input logic             wr_en,
   input logic [1:0]       wr_addr,
   input logic             gate_en,
   input logic             gate_in,
   input logic             pwm_o,
   input logic [CNT_W-1:0] act_on,
   input logic [CNT_W-1:0] cur_on
);
   always @(negedge clk) begin
      if (!rst_n) assert_reset_low_R1: assert (!pwm_o);
   end

   assert_commit_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_addr == 2'd1) |=> $stable(act_on));

   assert_gate_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_en && !gate_in) |-> !pwm_o);

   assert_idle_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en |=> !pwm_o);

   assert_zero_on_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_on == '0) |-> !pwm_o);
endmodule

bind dutyword_pwm dutyword_pwm_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .run_en(run_en), .wr_en(wr_en),
   .wr_addr(wr_addr), .gate_en(gate_en), .gate_in(gate_in),
   .pwm_o(pwm_o), .act_on(act_on), .cur_on(cur_on)
);

// File: tb/dutyword_pwm_bench.sv
module dutyword_pwm_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_us = 1'b1;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic       run_en = 1'b0;
   logic       one_shot = 1'b0;
   logic       gate_en = 1'b0;
   logic       gate_in = 1'b0;
   logic       pwm_o;
   int         total = 0;
   int         bad = 0;
   int         errs;

   localparam int NVEC = 5;
   localparam logic [31:0] VEC [NVEC] = '{
      32'h0001_0001, 32'h0002_0003, 32'h0005_0001,
      32'h0003_0007, 32'h0102_0101
   };

   always #5 clk = ~clk;

   dutyword_pwm u_dutyword_pwm (
      .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .run_en(run_en),
      .one_shot(one_shot), .gate_en(gate_en), .gate_in(gate_in),
      .pwm_o(pwm_o)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic program_pair(input logic [15:0] on, input logic [15:0] off);
      wr(2'd2, off[7:0]);
      wr(2'd3, off[15:8]);
      wr(2'd0, on[7:0]);
      wr(2'd1, on[15:8]);
   endtask

   task automatic stop_run();
      @(negedge clk);
      run_en = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check(pwm_o === 1'b0, "R1 reset output", pwm_o, 0);
      rst_n = 1'b1;
      @(negedge clk);
      run_en = 1'b1;
      errs = 0;
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         if (pwm_o !== 1'b0) errs++;
      end
      check(errs == 0, "R1 unprogrammed counts zero", errs, 0);
      stop_run();

      // R3 R4 R5: table of on/off pairs, two full continuous periods each
      for (int v = 0; v < NVEC; v++) begin
         int on, off, per;
         on = int'(VEC[v][31:16]);
         off = int'(VEC[v][15:0]);
         per = on + off;
         program_pair(VEC[v][31:16], VEC[v][15:0]);
         run_en = 1'b1;
         errs = 0;
         for (int k = 0; k < 2 * per; k++) begin
            @(negedge clk);
            if (pwm_o !== ((k % per) < on)) errs++;
         end
         check(errs == 0, "R3 R4 R5 vector", errs, 0);
         stop_run();
      end

      // R2 R9: mid-period commit, shadow writes first
      program_pair(16'd3, 16'd3);
      run_en = 1'b1;
      errs = 0;
      begin
         int errs_old;
         errs_old = 0;
         for (int k = 0; k < 18; k++) begin
            logic e;
            @(negedge clk);
            e = (k < 6) ? (k < 3) : (((k - 6) % 3) == 0);
            if (pwm_o !== e) begin
               if (k < 6) errs_old++; else errs++;
            end
            wr_en = 1'b0;
            case (k)
               0: begin wr_en = 1'b1; wr_addr = 2'd0; wr_data = 8'd1; end
               1: begin wr_en = 1'b1; wr_addr = 2'd2; wr_data = 8'd2; end
               2: begin wr_en = 1'b1; wr_addr = 2'd3; wr_data = 8'd0; end
               3: begin wr_en = 1'b1; wr_addr = 2'd1; wr_data = 8'd0; end
               default: ;
            endcase
         end
         check(errs_old == 0, "R2 shadow writes inert", errs_old, 0);
      end
      check(errs == 0, "R9 mid-period commit at next high", errs, 0);
      stop_run();

      // R9: commit on the same edge as a high-phase start
      program_pair(16'd2, 16'd2);
      wr(2'd0, 8'd1);
      wr(2'd2, 8'd3);
      wr(2'd3, 8'd0);
      run_en = 1'b1;
      errs = 0;
      for (int k = 0; k < 12; k++) begin
         logic e;
         @(negedge clk);
         e = (k < 4) ? (k < 2) : (((k - 4) % 4) == 0);
         if (pwm_o !== e) errs++;
         wr_en = (k == 3);
         wr_addr = 2'd1;
         wr_data = 8'd0;
      end
      wr_en = 1'b0;
      check(errs == 0, "R9 same-edge commit", errs, 0);
      stop_run();

      // R6: one-shot
      one_shot = 1'b1;
      program_pair(16'd3, 16'd2);
      run_en = 1'b1;
      errs = 0;
      for (int k = 0; k < 15; k++) begin
         @(negedge clk);
         if (pwm_o !== (k < 3)) errs++;
      end
      check(errs == 0, "R6 single pulse then low", errs, 0);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 2'd1; wr_data = 8'd0;
      errs = 0;
      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         wr_en = 1'b0;
         if (pwm_o !== (k < 3)) errs++;
      end
      check(errs == 0, "R6 restart by commit", errs, 0);
      stop_run();
      run_en = 1'b1;
      errs = 0;
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         if (pwm_o !== (k < 3)) errs++;
      end
      check(errs == 0, "R6 restart by re-enable", errs, 0);
      one_shot = 1'b0;
      stop_run();

      // R8: disable mid-high, counter cleared
      program_pair(16'd4, 16'd4);
      run_en = 1'b1;
      repeat (2) @(negedge clk);
      run_en = 1'b0;
      errs = 0;
      for (int k = 0; k < 5; k++) begin
         @(negedge clk);
         if (pwm_o !== 1'b0) errs++;
      end
      check(errs == 0, "R8 disabled output low", errs, 0);
      run_en = 1'b1;
      errs = 0;
      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         if (pwm_o !== (k < 4)) errs++;
      end
      check(errs == 0, "R8 full phase after re-enable", errs, 0);
      stop_run();

      // R3: counters hold while tick is low
      run_en = 1'b1;
      repeat (2) @(negedge clk);
      tick_us = 1'b0;
      errs = 0;
      for (int k = 0; k < 10; k++) begin
         @(negedge clk);
         if (pwm_o !== 1'b1) errs++;
      end
      tick_us = 1'b1;
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         if (pwm_o !== (k < 2)) errs++;
      end
      check(errs == 0, "R3 tick gating", errs, 0);
      stop_run();

      // R10: zero counts
      program_pair(16'd0, 16'd5);
      run_en = 1'b1;
      errs = 0;
      for (int k = 0; k < 20; k++) begin
         @(negedge clk);
         if (pwm_o !== 1'b0) errs++;
      end
      check(errs == 0, "R10 zero on-time low", errs, 0);
      stop_run();
      program_pair(16'd5, 16'd0);
      run_en = 1'b1;
      errs = 0;
      for (int k = 0; k < 20; k++) begin
         @(negedge clk);
         if (pwm_o !== 1'b1) errs++;
      end
      check(errs == 0, "R10 zero off-time high", errs, 0);

      // R7: external gate while output is held high
      gate_en = 1'b1; gate_in = 1'b0;
      @(negedge clk);
      check(pwm_o === 1'b0, "R7 gate closed", pwm_o, 0);
      gate_in = 1'b1;
      @(negedge clk);
      check(pwm_o === 1'b1, "R7 gate open", pwm_o, 1);
      gate_en = 1'b0; gate_in = 1'b0;
      @(negedge clk);
      check(pwm_o === 1'b1, "R7 gate input ignored", pwm_o, 1);
      stop_run();

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule